// File: doc/BRIEF.md
# Banked Free-Register Rename Allocator

This block hands out physical rename buffers to instruction destinations in an out-of-order core whose physical register file is split into equal banks. Instead of one global free list, every bank owns a small circular free FIFO holding only the tags of that bank. When a destination is renamed, its logical register number alone decides the bank: the logical space is cut into as many consecutive groups as there are banks, and group k draws only from bank k. Because the bank follows from the instruction's register fields, the bank that will be written is known ahead of the access, and the other banks can stay in a low-leakage state.

Per cycle the block accepts one destination allocation, one returned tag and a configurable number of source lookups. Source lookups read the logical-to-physical map before this cycle's allocation is written. A returned tag goes back into the FIFO of the bank its own value belongs to. The bank count is a parameter; banks of 4, 5 and 6 are supported, with bank sizes rounded up and the last bank taking the remainder. Each bank reports its free-tag count, an empty flag and a stall flag raised when an allocation aims at it while it holds no free tag.

Top module: `rra_banked_alloc`

## Requirements
- R1: After reset every bank's free count equals its tag count minus the logical registers of its group (48 for each bank with the defaults), no bank reports empty and no stall is raised.
- R2: After reset, logical register l is mapped to physical tag bank*64 + (l mod 16), where bank = l[5:4]; for example l=37 reads 133.
- R3: An allocation for logical register l is served by bank l[5:4] in the same cycle: alloc_grant is high and alloc_tag lies in that bank's range [64*bank, 64*bank+63]; the first tag a bank gives after reset is 64*bank+16, then ascending.
- R4: A granted allocation reports the previous mapping on alloc_prev_tag in the same cycle and writes the new tag into the map from the next cycle on.
- R5: A source lookup returns the mapping as it was before any allocation made in the same cycle.
- R6: A released tag is pushed into the FIFO of the bank given by the tag's bits [7:6] and is handed out only after the tags already queued in that bank.
- R7: An allocation aimed at a bank with zero free tags raises only that bank's bank_stall bit, drops alloc_grant, pops nothing and leaves the map unchanged.
- R8: An allocation and a release that hit the same bank in one cycle leave that bank's count unchanged; a release into an empty bank while it is being stalled makes its count 1.
- R9: A release into a bank holding 64 free tags is dropped unless the same bank is granted an allocation in that cycle, so the count never exceeds 64.
- R10: bank_empty bit b is high exactly when bank b's free count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| alloc_valid | input | 1 | A destination needs a new physical tag this cycle |
| alloc_lreg | input | 6 | Logical destination register |
| alloc_grant | output | 1 | Allocation served this cycle |
| alloc_tag | output | 8 | New physical tag (0 when not granted) |
| alloc_prev_tag | output | 8 | Physical tag mapped to alloc_lreg before this allocation |
| rel_valid | input | 1 | A physical tag is being returned |
| rel_tag | input | 8 | Returned physical tag |
| src_lreg | input | 12 | Source logical registers, port i in bits [6i+5:6i] |
| src_tag | output | 16 | Current physical tags of the sources, port i in bits [8i+7:8i] |
| bank_empty | output | 4 | Per-bank free FIFO empty |
| bank_count | output | 28 | Per-bank free count, bank b in bits [7b+6:7b] |
| bank_stall | output | 4 | Per-bank stall: allocation aimed at an empty bank |

## Verification
The bench drains one bank completely, checking that tags leave in strict ascending order, then aims an allocation at it: a design that popped anyway would hand out a stale tag and wrap the count, and one that flagged the wrong bank would stall unrelated renames. It fills another bank to its limit with returned tags and sends one more, alone and then together with an allocation, so a design that overflowed would report 65 and one that refused the paired release would fall to 63. Same-cycle source lookups and allocations to the same register catch a map that forwards the new tag too early, and a returned tag is followed through its bank's queue to catch steering by the logical number instead of the tag.

// File: rtl/rra_pkg.sv
`timescale 1ns/1ps
package rra_pkg;
  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int min_int(input int a, input int b);
    return (a < b) ? a : b;
  endfunction
endpackage

// File: rtl/rra_rst_sync.sv
`timescale 1ns/1ps
module rra_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      srst_n <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      srst_n <= meta_q;
    end
  end
endmodule

// File: rtl/rra_steer.sv
`timescale 1ns/1ps
module rra_steer #(
  parameter int W   = 6,
  parameter int PER = 16,
  parameter int BW  = 2
) (
  input  logic [W-1:0]  val,
  output logic [BW-1:0] bank
);
  logic [31:0] quo;

  always_comb begin
    quo  = 32'(val) / 32'(PER);
    bank = BW'(quo);
  end
endmodule

// File: rtl/rra_free_fifo.sv
`timescale 1ns/1ps
module rra_free_fifo #(
  parameter int DEPTH = 64,
  parameter int TW    = 8,
  parameter int BASE  = 16,
  parameter int INIT  = 48,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [TW-1:0] push_tag,
  input  logic          pop,
  output logic [TW-1:0] head_tag,
  output logic          empty,
  output logic          full,
  output logic [CW-1:0] count
);
  localparam int DW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [TW-1:0] mem [DEPTH];
  logic [DW-1:0] head_q, head_d, tail_q, tail_d;
  logic [CW-1:0] cnt_q, cnt_d;

  function automatic logic [DW-1:0] step_ptr(input logic [DW-1:0] p);
    return (p == DW'(DEPTH - 1)) ? '0 : p + DW'(1);
  endfunction

  always_comb begin
    head_d = pop  ? step_ptr(head_q) : head_q;
    tail_d = push ? step_ptr(tail_q) : tail_q;
    cnt_d  = cnt_q + CW'(push) - CW'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= DW'(INIT % DEPTH);
      cnt_q  <= CW'(INIT);
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++)
        mem[i] <= (i < INIT) ? TW'(BASE + i) : '0;
    end else if (push) begin
      mem[tail_q] <= push_tag;
    end
  end

  assign head_tag = mem[head_q];
  assign empty    = (cnt_q == '0);
  assign full     = (cnt_q == CW'(DEPTH));
  assign count    = cnt_q;

  // R7
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> cnt_q != '0);
  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |-> cnt_q != CW'(DEPTH));
  // R9
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
endmodule

// File: rtl/rra_bank.sv
`timescale 1ns/1ps
module rra_bank #(
  parameter int DEPTH = 64,
  parameter int TW    = 8,
  parameter int LPB   = 16,
  parameter int IW    = 4,
  parameter int CW    = 7,
  parameter int BASE  = 0,
  parameter int BSZ   = 64,
  parameter int NMAP  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    pop,
  input  logic                    push,
  input  logic [TW-1:0]           push_tag,
  output logic [TW-1:0]           head_tag,
  output logic                    empty,
  output logic                    full,
  output logic [CW-1:0]           count,
  input  logic [IW-1:0]           map_idx,
  output logic [LPB-1:0][TW-1:0]  map_q
);
  logic [LPB-1:0][TW-1:0] map_d;

  rra_free_fifo #(
    .DEPTH (DEPTH),
    .TW    (TW),
    .BASE  (BASE + NMAP),
    .INIT  (BSZ - NMAP),
    .CW    (CW)
  ) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (push),
    .push_tag (push_tag),
    .pop      (pop),
    .head_tag (head_tag),
    .empty    (empty),
    .full     (full),
    .count    (count)
  );

  always_comb begin
    map_d = map_q;
    if (pop) map_d[map_idx] = head_tag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LPB; i++)
        map_q[i] <= (i < NMAP) ? TW'(BASE + i) : '0;
    end else if (pop) begin
      map_q <= map_d;
    end
  end
endmodule

// File: rtl/rra_banked_alloc.sv
`timescale 1ns/1ps
module rra_banked_alloc #(
  parameter int NUM_PHYS  = 256,
  parameter int NUM_LOG   = 64,
  parameter int NUM_BANKS = 4,
  parameter int NUM_SRC   = 2,
  localparam int TW  = $clog2(NUM_PHYS),
  localparam int LW  = $clog2(NUM_LOG),
  localparam int BW  = $clog2(NUM_BANKS),
  localparam int PPB = rra_pkg::ceil_div(NUM_PHYS, NUM_BANKS),
  localparam int LPB = rra_pkg::ceil_div(NUM_LOG, NUM_BANKS),
  localparam int CW  = $clog2(PPB + 1),
  localparam int IW  = (LPB > 1) ? $clog2(LPB) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      alloc_valid,
  input  logic [LW-1:0]             alloc_lreg,
  output logic                      alloc_grant,
  output logic [TW-1:0]             alloc_tag,
  output logic [TW-1:0]             alloc_prev_tag,
  input  logic                      rel_valid,
  input  logic [TW-1:0]             rel_tag,
  input  logic [NUM_SRC*LW-1:0]     src_lreg,
  output logic [NUM_SRC*TW-1:0]     src_tag,
  output logic [NUM_BANKS-1:0]      bank_empty,
  output logic [NUM_BANKS*CW-1:0]   bank_count,
  output logic [NUM_BANKS-1:0]      bank_stall
);
  logic                    srst_n;
  logic [BW-1:0]           alloc_bank, rel_bank;
  logic [IW-1:0]           alloc_off;
  logic [NUM_BANKS-1:0]    pop_v, push_v, full_v, empty_v;
  logic [TW-1:0]           head_v [NUM_BANKS];
  logic [LPB-1:0][TW-1:0]  map_v  [NUM_BANKS];
  logic [CW-1:0]           cnt_v  [NUM_BANKS];

  rra_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .srst_n(srst_n));

  rra_steer #(.W(LW), .PER(LPB), .BW(BW)) u_dst_steer (
    .val (alloc_lreg), .bank (alloc_bank));
  rra_steer #(.W(TW), .PER(PPB), .BW(BW)) u_rel_steer (
    .val (rel_tag), .bank (rel_bank));

  assign alloc_off = IW'(32'(alloc_lreg) - 32'(alloc_bank) * 32'(LPB));

  always_comb begin
    alloc_grant    = alloc_valid && !empty_v[alloc_bank];
    alloc_tag      = alloc_grant ? head_v[alloc_bank] : '0;
    alloc_prev_tag = map_v[alloc_bank][alloc_off];
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int BASE = b * PPB;
    localparam int BSZ  = rra_pkg::min_int(PPB, NUM_PHYS - BASE);
    localparam int NMAP = rra_pkg::min_int(LPB, NUM_LOG - b * LPB);

    always_comb begin
      pop_v[b]      = alloc_grant && (alloc_bank == BW'(b));
      push_v[b]     = rel_valid && (rel_bank == BW'(b)) && (!full_v[b] || pop_v[b]);
      bank_stall[b] = alloc_valid && (alloc_bank == BW'(b)) && empty_v[b];
    end

    rra_bank #(
      .DEPTH (PPB), .TW (TW), .LPB (LPB), .IW (IW), .CW (CW),
      .BASE  (BASE), .BSZ (BSZ), .NMAP (NMAP)
    ) u_bank (
      .clk      (clk),
      .rst_n    (srst_n),
      .pop      (pop_v[b]),
      .push     (push_v[b]),
      .push_tag (rel_tag),
      .head_tag (head_v[b]),
      .empty    (empty_v[b]),
      .full     (full_v[b]),
      .count    (cnt_v[b]),
      .map_idx  (alloc_off),
      .map_q    (map_v[b])
    );

    assign bank_count[b*CW +: CW] = cnt_v[b];
    assign bank_empty[b]          = empty_v[b];
  end

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    logic [BW-1:0] sbank;
    logic [IW-1:0] soff;
    rra_steer #(.W(LW), .PER(LPB), .BW(BW)) u_src_steer (
      .val (src_lreg[s*LW +: LW]), .bank (sbank));
    always_comb begin
      soff = IW'(32'(src_lreg[s*LW +: LW]) - 32'(sbank) * 32'(LPB));
      src_tag[s*TW +: TW] = map_v[sbank][soff];
    end
  end

  // R3
  tag_in_bank_chk: assert property (@(posedge clk) disable iff (!srst_n)
    alloc_grant |-> (32'(alloc_tag) / 32'(PPB)) == 32'(alloc_bank));
  // R3
  single_pop_chk: assert property (@(posedge clk) disable iff (!srst_n)
    $countones(pop_v) == (alloc_grant ? 1 : 0));
  // R7
  stall_onehot_chk: assert property (@(posedge clk) disable iff (!srst_n)
    $onehot0(bank_stall));
  // R7
  stall_excl_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (|bank_stall) |-> !alloc_grant);
  // R4
  map_write_chk: assert property (@(posedge clk) disable iff (!srst_n)
    alloc_grant |=> map_v[$past(alloc_bank)][$past(alloc_off)] == $past(alloc_tag));
endmodule

// File: tb/sim_rra_banked_alloc.sv
`timescale 1ns/1ps
module sim_rra_banked_alloc;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        alloc_valid;
  logic [5:0]  alloc_lreg;
  logic        alloc_grant;
  logic [7:0]  alloc_tag, alloc_prev_tag;
  logic        rel_valid;
  logic [7:0]  rel_tag;
  logic [11:0] src_lreg;
  logic [15:0] src_tag;
  logic [3:0]  bank_empty, bank_stall;
  logic [27:0] bank_count;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  rra_banked_alloc u0 (
    .clk (clk), .rst_n (rst_n),
    .alloc_valid (alloc_valid), .alloc_lreg (alloc_lreg),
    .alloc_grant (alloc_grant), .alloc_tag (alloc_tag),
    .alloc_prev_tag (alloc_prev_tag),
    .rel_valid (rel_valid), .rel_tag (rel_tag),
    .src_lreg (src_lreg), .src_tag (src_tag),
    .bank_empty (bank_empty), .bank_count (bank_count),
    .bank_stall (bank_stall)
  );

  typedef struct packed {
    logic       av;
    logic [5:0] al;
    logic       rv;
    logic [7:0] rt;
    logic [5:0] s0;
    logic       eg;
    logic [7:0] et;
    logic [7:0] ep;
    logic [7:0] es;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 6'd0,  1'b0, 8'd0,   6'd0,  1'b1, 8'd16,  8'd0,   8'd0},
    '{1'b1, 6'd20, 1'b0, 8'd0,   6'd0,  1'b1, 8'd80,  8'd68,  8'd16},
    '{1'b1, 6'd63, 1'b0, 8'd0,   6'd63, 1'b1, 8'd208, 8'd207, 8'd207},
    '{1'b0, 6'd0,  1'b1, 8'd5,   6'd63, 1'b0, 8'd0,   8'd0,   8'd208},
    '{1'b1, 6'd1,  1'b0, 8'd0,   6'd20, 1'b1, 8'd17,  8'd1,   8'd80},
    '{1'b1, 6'd47, 1'b1, 8'd130, 6'd47, 1'b1, 8'd144, 8'd143, 8'd143},
    '{1'b1, 6'd0,  1'b0, 8'd0,   6'd0,  1'b1, 8'd18,  8'd16,  8'd16}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int cnt(input int b);
    return int'(bank_count[b*7 +: 7]);
  endfunction

  task automatic drive(input logic av, input int al, input logic rv, input int rt,
                       input int s0, input int s1);
    @(negedge clk);
    alloc_valid = av;
    alloc_lreg  = 6'(al);
    rel_valid   = rv;
    rel_tag     = 8'(rt);
    src_lreg    = {6'(s1), 6'(s0)};
    #1;
  endtask

  task automatic idle(input int s0, input int s1);
    drive(1'b0, 0, 1'b0, 0, s0, s1);
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    alloc_valid = 1'b0; alloc_lreg = '0; rel_valid = 1'b0; rel_tag = '0; src_lreg = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    do_reset();

    // R1 R2: reset state
    idle(37, 10);
    for (int b = 0; b < 4; b++) chk("R1 reset count", cnt(b), 48);
    chk("R1 reset empty", int'(bank_empty), 0);
    chk("R1 reset stall", int'(bank_stall), 0);
    chk("R2 reset map l37", int'(src_tag[7:0]), 133);
    chk("R2 reset map l10", int'(src_tag[15:8]), 10);

    // Vector table: R3 R4 R5 R6 R8
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].av, int'(VEC[i].al), VEC[i].rv, int'(VEC[i].rt), int'(VEC[i].s0), 0);
      chk("R3 grant", int'(alloc_grant), int'(VEC[i].eg));
      chk("R5 source lookup", int'(src_tag[7:0]), int'(VEC[i].es));
      if (VEC[i].av) begin
        chk("R3 alloc tag", int'(alloc_tag), int'(VEC[i].et));
        chk("R4 prev tag", int'(alloc_prev_tag), int'(VEC[i].ep));
      end
    end
    idle(0, 0);
    chk("R6 bank0 count after release", cnt(0), 46);
    chk("R3 bank1 count", cnt(1), 47);
    chk("R8 bank2 alloc+release count", cnt(2), 48);
    chk("R3 bank3 count", cnt(3), 47);

    // R3 R10: drain bank 1 in order
    do_reset();
    for (int i = 0; i < 48; i++) begin
      drive(1'b1, 16, 1'b0, 0, 0, 0);
      chk("R3 drain order", int'(alloc_tag), 80 + i);
    end
    idle(0, 0);
    chk("R10 drained count", cnt(1), 0);
    chk("R10 empty flags", int'(bank_empty), 4'b0010);

    // R7: allocation to empty bank
    drive(1'b1, 17, 1'b0, 0, 0, 0);
    chk("R7 no grant", int'(alloc_grant), 0);
    chk("R7 stall bit", int'(bank_stall), 4'b0010);
    idle(17, 16);
    chk("R7 count held", cnt(1), 0);
    chk("R7 map unchanged", int'(src_tag[7:0]), 65);
    chk("R4 last drained map", int'(src_tag[15:8]), 127);

    // R8: release into an empty bank while stalled
    drive(1'b1, 18, 1'b1, 100, 0, 0);
    chk("R8 stall with release", int'(bank_stall), 4'b0010);
    idle(0, 0);
    chk("R8 count after release", cnt(1), 1);
    chk("R10 empty cleared", int'(bank_empty), 0);

    // R6: released tag reused
    drive(1'b1, 18, 1'b0, 0, 0, 0);
    chk("R6 reuse tag", int'(alloc_tag), 100);
    chk("R4 prev before reuse", int'(alloc_prev_tag), 66);
    idle(18, 0);
    chk("R4 map after reuse", int'(src_tag[7:0]), 100);

    // R9: fill bank 3 and overflow it
    for (int i = 0; i < 16; i++) drive(1'b0, 0, 1'b1, 192 + i, 0, 0);
    idle(0, 0);
    chk("R9 bank3 full", cnt(3), 64);
    drive(1'b0, 0, 1'b1, 200, 0, 0);
    idle(0, 0);
    chk("R9 release dropped", cnt(3), 64);
    drive(1'b1, 48, 1'b1, 201, 0, 0);
    chk("R3 alloc from full bank", int'(alloc_tag), 208);
    idle(0, 0);
    chk("R9 paired release accepted", cnt(3), 64);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule